// File: doc/BRIEF.md
# Banked Status Flag Unit

This unit holds the carry and zero status bits of a small processor core in two separate hardware banks. One bank serves ordinary program execution and the other serves interrupt handlers. The unit tracks the current execution mode and connects the bank for that mode to the flag outputs. Only the connected bank can be read or written.

When the core takes an interrupt, the unit switches to the interrupt bank in the same edge. No instruction is needed for the switch, and neither bank is saved or cleared. On a return strobe, the unit restores the mode that was active before the matching entry. It keeps a short mode history of parameterised depth for this purpose, so nested entries return to the interrupt bank until the outermost return. Each flag-updating operation writes a new carry and zero value into the bank that was active at that clock edge. The flag values come from the ALU result and the ALU's carry/borrow line.

Top module: `banked_flag_unit`

## Requirements
- R1: Reset sets mode_o to 0 (normal) and clears carry and zero in both banks. After reset, the outputs read 0/0, and they still read 0/0 after a later entry to the interrupt bank.
- R2: A cycle with irq_enter high makes mode_o read 1 (interrupt) from the next cycle. This holds even if the unit was already in interrupt mode.
- R3: A cycle with irq_return high and irq_enter low restores the mode saved by the most recent unreturned entry. The history holds HIST_DEPTH entries. A return with an empty history selects normal mode. An entry with a full history discards the oldest saved mode.
- R4: A flag update writes only the bank selected by the current mode. The other bank keeps its values.
- R5: Switching modes never alters either bank. Each bank shows again the values it held when its mode was last left.
- R6: When upd_arith is high, the active bank's carry takes the value of alu_carry. Its zero is set to 1 exactly when alu_result equals zero.
- R7: When upd_logic is high and upd_arith is low, the active bank's carry is cleared. Its zero is set to 1 exactly when alu_result equals zero.
- R8: An update in the same cycle as irq_enter or irq_return goes to the bank that was active before that edge.
- R9: When irq_enter and irq_return are high together, the entry is taken and the return is ignored.
- R10: When upd_arith and upd_logic are high together, the arithmetic rule (R6) applies.
- R11: In a cycle with no update and no strobe, carry_o, zero_o and mode_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_result | input | WIDTH | Result of the operation that updates the flags |
| alu_carry | input | 1 | Carry or borrow produced by an arithmetic operation |
| upd_arith | input | 1 | Arithmetic flag update for this cycle |
| upd_logic | input | 1 | Logic flag update for this cycle |
| irq_enter | input | 1 | Interrupt taken this cycle |
| irq_return | input | 1 | Return from interrupt this cycle |
| carry_o | output | 1 | Carry flag of the active bank |
| zero_o | output | 1 | Zero flag of the active bank |
| mode_o | output | 1 | Current mode: 0 normal, 1 interrupt |

## Verification
A wrong bank select appears at the ports one cycle after the update or strobe that caused it. The flag outputs then show values from the other bank, or mode_o disagrees with the count of entries and returns. A bank that was corrupted while hidden stays invisible until its mode comes back. For this reason, the bench sweeps every result value and carry in each mode and then switches back before comparing. A broken history shows up at the first return that restores the wrong mode. The bench therefore nests entries past the history depth and unwinds them one return at a time.

// File: rtl/bflag_pkg.sv
package bflag_pkg;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_IRQ    = 1'b1
    } exec_mode_e;

    localparam int NUM_BANKS = 2;

    typedef struct packed {
        logic carry;
        logic zero;
    } flag_pair_t;

endpackage

// File: rtl/bflag_eval.sv
module bflag_eval
    import bflag_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] result_i,
    input  logic             carry_i,
    input  logic             arith_i,
    input  logic             logic_i,
    output logic             write_o,
    output flag_pair_t       pair_o
);

    always_comb begin
        write_o     = arith_i | logic_i;
        pair_o.zero = (result_i == '0);
        // Arithmetic takes precedence when both requests are present
        pair_o.carry = arith_i ? carry_i : 1'b0;
    end

endmodule

// File: rtl/bflag_bank.sv
module bflag_bank
    import bflag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  flag_pair_t wdata_i,
    output flag_pair_t q_o
);

    typedef struct packed {
        flag_pair_t pair;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.pair = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.pair;

endmodule

// File: rtl/bflag_mode_track.sv
module bflag_mode_track
    import bflag_pkg::*;
#(
    parameter int HIST_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enter_i,
    input  logic       return_i,
    output exec_mode_e mode_o
);

    localparam int CNT_W = $clog2(HIST_DEPTH + 1);

    typedef struct packed {
        exec_mode_e            mode;
        logic [HIST_DEPTH-1:0] hist;
        logic [CNT_W-1:0]      cnt;
    } track_state_t;

    track_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (enter_i) begin
            if (st_q.cnt < CNT_W'(HIST_DEPTH)) begin
                for (int i = 0; i < HIST_DEPTH; i++) begin
                    if (CNT_W'(i) == st_q.cnt) begin
                        st_d.hist[i] = st_q.mode;
                    end
                end
                st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                // Full: drop the oldest saved mode, keep the newest on top
                for (int i = 0; i < HIST_DEPTH - 1; i++) begin
                    st_d.hist[i] = st_q.hist[i+1];
                end
                st_d.hist[HIST_DEPTH-1] = st_q.mode;
            end
            st_d.mode = MODE_IRQ;
        end else if (return_i) begin
            if (st_q.cnt != '0) begin
                st_d.mode = MODE_NORMAL;
                for (int i = 0; i < HIST_DEPTH; i++) begin
                    if (CNT_W'(i + 1) == st_q.cnt) begin
                        st_d.mode = exec_mode_e'(st_q.hist[i]);
                    end
                end
                st_d.cnt = st_q.cnt - 1'b1;
            end else begin
                st_d.mode = MODE_NORMAL;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_NORMAL, hist: '0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;

endmodule

// File: rtl/banked_flag_unit.sv
module banked_flag_unit
    import bflag_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int HIST_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] alu_result,
    input  logic             alu_carry,
    input  logic             upd_arith,
    input  logic             upd_logic,
    input  logic             irq_enter,
    input  logic             irq_return,
    output logic             carry_o,
    output logic             zero_o,
    output logic             mode_o
);

    exec_mode_e mode_q;
    logic       flag_we;
    flag_pair_t flag_new;
    flag_pair_t bank_q [NUM_BANKS];

    bflag_eval #(.WIDTH(WIDTH)) u_eval (
        .result_i (alu_result),
        .carry_i  (alu_carry),
        .arith_i  (upd_arith),
        .logic_i  (upd_logic),
        .write_o  (flag_we),
        .pair_o   (flag_new)
    );

    bflag_mode_track #(.HIST_DEPTH(HIST_DEPTH)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .enter_i  (irq_enter),
        .return_i (irq_return),
        .mode_o   (mode_q)
    );

    // The write goes to the bank selected before this edge's switch
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_we;
        assign bank_we = flag_we && (int'(mode_q) == b);
        bflag_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (bank_we),
            .wdata_i (flag_new),
            .q_o     (bank_q[b])
        );
    end

    always_comb begin
        carry_o = bank_q[int'(mode_q)].carry;
        zero_o  = bank_q[int'(mode_q)].zero;
        mode_o  = mode_q;
    end

endmodule

// File: rtl/bflag_checker.sv
module bflag_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] alu_result,
    input logic             alu_carry,
    input logic             upd_arith,
    input logic             upd_logic,
    input logic             irq_enter,
    input logic             irq_return,
    input logic             carry_o,
    input logic             zero_o,
    input logic             mode_o
);

    AST_ENTER_SELECTS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_enter |=> mode_o); // R2

    AST_ARITH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_arith && !irq_enter && !irq_return) |=>
            (carry_o == $past(alu_carry)) && (zero_o == ($past(alu_result) == '0))); // R6

    AST_LOGIC_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_logic && !upd_arith && !irq_enter && !irq_return) |=>
            !carry_o && (zero_o == ($past(alu_result) == '0))); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_arith && !upd_logic && !irq_enter && !irq_return) |=>
            $stable(carry_o) && $stable(zero_o) && $stable(mode_o)); // R11

    AST_RETURN_EMPTY_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_return && !irq_enter && !mode_o) |=> !mode_o); // R3

endmodule

bind banked_flag_unit bflag_checker #(.WIDTH(WIDTH)) u_bflag_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .alu_result (alu_result),
    .alu_carry  (alu_carry),
    .upd_arith  (upd_arith),
    .upd_logic  (upd_logic),
    .irq_enter  (irq_enter),
    .irq_return (irq_return),
    .carry_o    (carry_o),
    .zero_o     (zero_o),
    .mode_o     (mode_o)
);

// File: tb/tb_banked_flag_unit.sv
module tb_banked_flag_unit;

    localparam int W = 8;
    localparam int D = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] alu_result = '0;
    logic         alu_carry = 1'b0;
    logic         upd_arith = 1'b0;
    logic         upd_logic = 1'b0;
    logic         irq_enter = 1'b0;
    logic         irq_return = 1'b0;
    logic         carry_o, zero_o, mode_o;

    int n_chk = 0;
    int n_fail = 0;

    // Reference state
    bit m_c [2];
    bit m_z [2];
    bit m_mode;
    bit m_hist [D];
    int m_cnt;

    always #2 clk = ~clk;

    banked_flag_unit #(.WIDTH(W), .HIST_DEPTH(D)) dut (
        .clk(clk), .rst_n(rst_n), .alu_result(alu_result), .alu_carry(alu_carry),
        .upd_arith(upd_arith), .upd_logic(upd_logic), .irq_enter(irq_enter),
        .irq_return(irq_return), .carry_o(carry_o), .zero_o(zero_o), .mode_o(mode_o)
    );

    function automatic void model_reset();
        m_c[0] = 0; m_c[1] = 0; m_z[0] = 0; m_z[1] = 0;
        m_mode = 0; m_cnt = 0;
        for (int i = 0; i < D; i++) m_hist[i] = 0;
    endfunction

    task automatic check(string req);
        n_chk++;
        if (carry_o !== m_c[m_mode] || zero_o !== m_z[m_mode] || mode_o !== m_mode) begin
            n_fail++;
            $display("FAIL %s: got c=%b z=%b m=%b expected c=%b z=%b m=%b",
                     req, carry_o, zero_o, mode_o, m_c[m_mode], m_z[m_mode], m_mode);
        end
    endtask

    task automatic step(input logic [W-1:0] res, input bit cy, input bit ua, input bit ul,
                        input bit en, input bit rt, input string req);
        bit old;
        @(negedge clk);
        alu_result = res; alu_carry = cy; upd_arith = ua; upd_logic = ul;
        irq_enter = en; irq_return = rt;
        @(posedge clk);
        old = m_mode;
        if (ua) begin
            m_c[old] = cy; m_z[old] = (res == 0);
        end else if (ul) begin
            m_c[old] = 0; m_z[old] = (res == 0);
        end
        if (en) begin
            if (m_cnt < D) begin
                m_hist[m_cnt] = m_mode; m_cnt++;
            end else begin
                for (int i = 0; i < D - 1; i++) m_hist[i] = m_hist[i+1];
                m_hist[D-1] = m_mode;
            end
            m_mode = 1;
        end else if (rt) begin
            if (m_cnt > 0) begin
                m_cnt--; m_mode = m_hist[m_cnt];
            end else begin
                m_mode = 0;
            end
        end
        #1;
        check(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        alu_result = '0; alu_carry = 0; upd_arith = 0; upd_logic = 0;
        irq_enter = 0; irq_return = 0;
        rst_n = 0;
        model_reset();
        @(negedge clk);
        check("R1");
        rst_n = 1;
    endtask

    task automatic sweep(string req);
        for (int r = 0; r < (1 << W); r++) begin
            for (int c = 0; c < 2; c++) begin
                step(W'(r), c[0], 1, 0, 0, 0, (req == "") ? "R6" : req);
                step(W'(r), c[0], 0, 1, 0, 0, (req == "") ? "R7" : req);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got hung run expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();
        step(8'h00, 0, 0, 0, 1, 0, "R1");       // interrupt bank also clear
        step(8'h00, 0, 0, 0, 0, 1, "R3");

        // Normal-mode sweep of every result and carry
        sweep("");
        step(8'h00, 1, 1, 0, 0, 0, "R6");       // normal: c=1 z=1
        step(8'h00, 0, 0, 0, 1, 0, "R2");
        sweep("R4");                            // interrupt bank only
        step(8'h5A, 0, 0, 1, 0, 0, "R7");       // irq: c=0 z=0
        step(8'h00, 0, 0, 0, 0, 1, "R5");       // normal values back
        step(8'h00, 0, 0, 0, 1, 0, "R5");       // irq values back

        // Updates coinciding with switches
        step(8'h00, 1, 1, 0, 0, 1, "R8");       // lands in irq bank
        step(8'h00, 0, 0, 0, 1, 0, "R8");
        step(8'h33, 1, 1, 0, 1, 0, "R8");       // lands in irq bank, nested entry
        step(8'h00, 0, 0, 0, 1, 1, "R9");
        step(8'h00, 0, 0, 0, 0, 0, "R11");
        step(8'h00, 1, 1, 1, 0, 0, "R10");
        step(8'h07, 1, 1, 1, 0, 0, "R10");

        // Nesting past the history depth, then unwinding
        do_reset();
        for (int i = 0; i < D + 2; i++) step(8'(i), i[0], 1, 0, 1, 0, "R3");
        for (int i = 0; i < D + 3; i++) step(8'h00, 0, 0, 0, 0, 1, "R3");
        step(8'h00, 0, 0, 0, 0, 1, "R3");       // empty history

        // Mixed random traffic
        for (int i = 0; i < 4000; i++) begin
            bit [5:0] k;
            k = 6'($urandom);
            step(W'($urandom_range(0, 3) == 0 ? 0 : $urandom), k[0], k[1], k[2],
                 (k[5:3] == 3'd0), (k[5:3] == 3'd1), "R4");
        end
        for (int i = 0; i < 6; i++) step(8'h00, 0, 0, 0, 0, 0, "R11");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule